// File: doc/BRIEF.md
# Lock-Line Reservation Unit

This unit gives a processing element an atomic read-modify-write on one 128-byte line of a shared address space. Software first issues a reserving get, which reads a line into the local side and arms a single reservation on that line. It then computes a new value and issues a conditional put. The put commits only while the reservation is still armed. If any other agent has written the line in the meantime, the put is refused and software retries the sequence. An unconditional put always commits.

A snoop input reports writes made to memory by other agents. Each such write lands in the memory model and kills a matching reservation. Addresses are compared on whole 128-byte lines, so the low seven address bits are ignored. A small line memory stands in for the data path: each line is held as one `DW`-bit word, and it is indexed by the low `log2(NLINES)` bits of the line number.

Top module: `llr_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after, `resv_held`, `get_valid` and `cond_done` are all low.
- R2: A command with `cmd_valid` high and `cmd_op` = 0 (reserving get) makes `get_valid` high in the next cycle, with `get_data` equal to the stored line. It also leaves `resv_held` high on that line.
- R3: A conditional put (`cmd_op` = 1) to the reserved line succeeds. The line match ignores address bits 6:0. A success writes `cmd_wdata` into the line and sets `cond_ok` high together with `cond_done` in the next cycle.
- R4: A conditional put with no reservation, or with a reservation on a different line, fails. It gives `cond_done` high and `cond_ok` low, and the stored line keeps its old value.
- R5: A conditional put clears the reservation whether it succeeds or fails, so `resv_held` is low in the next cycle.
- R6: A snooped write to the reserved line clears the reservation. A snooped write to any other line leaves it held. Every snooped write updates the stored line.
- R7: A reserving get replaces an existing reservation. A later conditional put to the earlier line fails.
- R8: An unconditional put (`cmd_op` = 2) always writes the line. It clears the reservation only when it targets the reserved line.
- R9: When a command and a snoop arrive in the same cycle, the command takes effect first. A reserving get then reads the old data and loses its new reservation to a matching snoop. A conditional put is judged before the snoop, and the snoop data wins the memory write.
- R10: `cond_done` is a one-cycle pulse, raised only in the cycle after a conditional put. `cmd_op` = 3 with `cmd_valid` high changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 reserving get, 1 conditional put, 2 unconditional put, 3 no-op |
| cmd_addr | input | AW | Effective address of the command |
| cmd_wdata | input | DW | Line value for a put |
| snoop_valid | input | 1 | Another agent wrote memory this cycle |
| snoop_addr | input | AW | Address of the snooped write |
| snoop_wdata | input | DW | Value of the snooped write |
| get_valid | output | 1 | Read data from a reserving get is present |
| get_data | output | DW | Line value read by the reserving get |
| cond_done | output | 1 | A conditional put completed |
| cond_ok | output | 1 | That conditional put committed |
| resv_held | output | 1 | A reservation is armed |

## Verification
The hardest case to reach from the ports is a foreign write in the same cycle as a command on the same line. Here the ordering rule decides both the status and the final line value. The stimulus arms a reservation, then applies a conditional put and a matching snoop together, and reads the line back with a later get to see which write survived. A reserving get colliding with a snoop is also driven, followed by a put that must fail. A scoreboard model fed by the driver predicts each cycle's outputs.

// File: rtl/llr_pkg.sv
package llr_pkg;

    // 128-byte granule: low address bits that never take part in a match
    localparam int unsigned LINE_OFS = 7;

    typedef enum logic [1:0] {
        OP_RGET = 2'd0,
        OP_CPUT = 2'd1,
        OP_UPUT = 2'd2,
        OP_NOP  = 2'd3
    } llr_op_e;

    typedef struct packed {
        logic done;
        logic ok;
    } cond_stat_t;

    function automatic logic op_is(input logic vld, input llr_op_e op, input llr_op_e want);
        return vld && (op == want);
    endfunction

endpackage

// File: rtl/llr_resv.sv
module llr_resv
    import llr_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  llr_op_e       cmd_op,
    input  logic [AW-1:0] cmd_line,
    input  logic          snp_valid,
    input  logic [AW-1:0] snp_line,
    output logic          put_ok,
    output logic          resv_v_q,
    output logic [AW-1:0] resv_line_q
);

    logic          hit_cmd;
    logic          mid_v;
    logic [AW-1:0] mid_line;
    logic          nxt_v;

    always_comb begin
        hit_cmd  = resv_v_q && (resv_line_q == cmd_line);
        put_ok   = op_is(cmd_valid, cmd_op, OP_CPUT) && hit_cmd;
        mid_v    = resv_v_q;
        mid_line = resv_line_q;
        // command takes effect first
        if (cmd_valid) begin
            unique case (cmd_op)
                OP_RGET: begin
                    mid_v    = 1'b1;
                    mid_line = cmd_line;
                end
                OP_CPUT: mid_v = 1'b0;
                OP_UPUT: if (hit_cmd) mid_v = 1'b0;
                default: ;
            endcase
        end
        // then the foreign write
        nxt_v = mid_v;
        if (snp_valid && mid_v && (snp_line == mid_line)) nxt_v = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resv_v_q    <= 1'b0;
            resv_line_q <= '0;
        end else begin
            resv_v_q    <= nxt_v;
            resv_line_q <= mid_line;
        end
    end

endmodule

// File: rtl/llr_linemem.sv
module llr_linemem #(
    parameter int unsigned DW     = 32,
    parameter int unsigned NLINES = 16,
    localparam int unsigned IW    = $clog2(NLINES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_idx,
    input  logic          wa_en,
    input  logic [IW-1:0] wa_idx,
    input  logic [DW-1:0] wa_data,
    input  logic          wb_en,
    input  logic [IW-1:0] wb_idx,
    input  logic [DW-1:0] wb_data,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] store [NLINES];

    // port B (foreign write) overrides port A (command) on the same line
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                store[g] <= '0;
            else if (wb_en && (wb_idx == IW'(g)))
                store[g] <= wb_data;
            else if (wa_en && (wa_idx == IW'(g)))
                store[g] <= wa_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= store[rd_idx];
        end
    end

endmodule

// File: rtl/llr_status.sv
module llr_status
    import llr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       put_cmd,
    input  logic       put_ok,
    output cond_stat_t stat_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q.done <= put_cmd;
            stat_q.ok   <= put_cmd && put_ok;
        end
    end

endmodule

// File: rtl/llr_unit.sv
module llr_unit
    import llr_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter int unsigned DW     = 32,
    parameter int unsigned NLINES = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    input  logic [DW-1:0] snoop_wdata,
    output logic          get_valid,
    output logic [DW-1:0] get_data,
    output logic          cond_done,
    output logic          cond_ok,
    output logic          resv_held
);

    localparam int unsigned IW = $clog2(NLINES);

    llr_op_e       op;
    logic [AW-1:0] cmd_line;
    logic [AW-1:0] snp_line;
    logic [AW-1:0] resv_line;
    logic          put_ok;
    logic          is_rget;
    logic          is_cput;
    logic          is_uput;
    logic          mem_wr;
    cond_stat_t    stat;

    assign op       = llr_op_e'(cmd_op);
    assign cmd_line = cmd_addr >> LINE_OFS;
    assign snp_line = snoop_addr >> LINE_OFS;
    assign is_rget  = op_is(cmd_valid, op, OP_RGET);
    assign is_cput  = op_is(cmd_valid, op, OP_CPUT);
    assign is_uput  = op_is(cmd_valid, op, OP_UPUT);
    assign mem_wr   = is_uput || put_ok;

    llr_resv #(.AW(AW)) i_resv (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_op      (op),
        .cmd_line    (cmd_line),
        .snp_valid   (snoop_valid),
        .snp_line    (snp_line),
        .put_ok      (put_ok),
        .resv_v_q    (resv_held),
        .resv_line_q (resv_line)
    );

    llr_linemem #(.DW(DW), .NLINES(NLINES)) i_mem (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (is_rget),
        .rd_idx   (cmd_line[IW-1:0]),
        .wa_en    (mem_wr),
        .wa_idx   (cmd_line[IW-1:0]),
        .wa_data  (cmd_wdata),
        .wb_en    (snoop_valid),
        .wb_idx   (snp_line[IW-1:0]),
        .wb_data  (snoop_wdata),
        .rd_valid (get_valid),
        .rd_data  (get_data)
    );

    llr_status i_stat (
        .clk     (clk),
        .rst     (rst),
        .put_cmd (is_cput),
        .put_ok  (put_ok),
        .stat_q  (stat)
    );

    assign cond_done = stat.done;
    assign cond_ok   = stat.ok;

endmodule

// File: rtl/llr_unit_chk.sv
module llr_unit_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic [1:0]    cmd_op,
    input logic [AW-1:0] cmd_addr,
    input logic          snoop_valid,
    input logic [AW-1:0] snoop_addr,
    input logic          get_valid,
    input logic          cond_done,
    input logic          cond_ok,
    input logic          resv_held,
    input logic [AW-1:0] resv_line
);

    logic [AW-1:0] c_line;
    logic [AW-1:0] s_line;
    assign c_line = cmd_addr >> 7;
    assign s_line = snoop_addr >> 7;

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!resv_held && !get_valid && !cond_done));

    a_r2_get_arms: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd0 && !(snoop_valid && s_line == c_line))
        |=> (resv_held && get_valid));

    a_r3_ok_implies_done: assert property (@(posedge clk) disable iff (rst)
        cond_ok |-> cond_done);

    a_r4_no_resv_fails: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd1 && !resv_held) |=> !cond_ok);

    a_r5_cput_clears: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd1) |=> (!resv_held && cond_done));

    a_r6_snoop_kills: assert property (@(posedge clk) disable iff (rst)
        (snoop_valid && !cmd_valid && resv_held && s_line == resv_line) |=> !resv_held);

    a_r10_done_only_after_cput: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd_op == 2'd1) |=> !cond_done);

endmodule

bind llr_unit llr_unit_chk #(.AW(AW)) i_llr_unit_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_addr    (cmd_addr),
    .snoop_valid (snoop_valid),
    .snoop_addr  (snoop_addr),
    .get_valid   (get_valid),
    .cond_done   (cond_done),
    .cond_ok     (cond_ok),
    .resv_held   (resv_held),
    .resv_line   (resv_line)
);

// File: tb/test_llr_unit.sv
`timescale 1ns/1ps
module test_llr_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd3;
    logic [31:0] cmd_addr = '0;
    logic [31:0] cmd_wdata = '0;
    logic        snoop_valid = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic [31:0] snoop_wdata = '0;
    logic        get_valid;
    logic [31:0] get_data;
    logic        cond_done;
    logic        cond_ok;
    logic        resv_held;

    always #10 clk = ~clk;

    llr_unit #(.AW(32), .DW(32), .NLINES(16)) i_llr_unit (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_wdata(snoop_wdata),
        .get_valid(get_valid), .get_data(get_data),
        .cond_done(cond_done), .cond_ok(cond_ok), .resv_held(resv_held)
    );

    typedef struct packed {
        logic        gv;
        logic [31:0] gd;
        logic        cd;
        logic        cok;
        logic        held;
    } exp_t;

    exp_t  q_exp[$];
    string q_req[$];
    int    n_vec = 0;
    int    n_err = 0;

    // requirement model
    logic [31:0] m_mem [16];
    logic        m_v = 1'b0;
    logic [31:0] m_line = '0;

    task automatic step(input string req, input logic cv, input logic [1:0] op,
                        input logic [31:0] a, input logic [31:0] d,
                        input logic sv, input logic [31:0] sa, input logic [31:0] sd);
        exp_t        e;
        logic [31:0] ln;
        logic [31:0] sln;
        @(negedge clk);
        cmd_valid = cv; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        snoop_valid = sv; snoop_addr = sa; snoop_wdata = sd;
        ln  = a >> 7;
        sln = sa >> 7;
        e   = '0;
        if (cv) begin
            case (op)
                2'd0: begin e.gv = 1'b1; e.gd = m_mem[ln[3:0]]; m_v = 1'b1; m_line = ln; end
                2'd1: begin
                    e.cd  = 1'b1;
                    e.cok = m_v && (m_line == ln);
                    if (e.cok) m_mem[ln[3:0]] = d;
                    m_v = 1'b0;
                end
                2'd2: begin m_mem[ln[3:0]] = d; if (m_v && m_line == ln) m_v = 1'b0; end
                default: ;
            endcase
        end
        if (sv) begin
            m_mem[sln[3:0]] = sd;
            if (m_v && m_line == sln) m_v = 1'b0;
        end
        e.held = m_v;
        q_exp.push_back(e);
        q_req.push_back(req);
    endtask

    task automatic idle(input string req);
        step(req, 1'b0, 2'd3, 32'h0, 32'h0, 1'b0, 32'h0, 32'h0);
    endtask

    // monitor: outputs registered on the edge after the drive
    initial begin
        exp_t  e;
        string r;
        forever begin
            @(posedge clk);
            #5;
            if (q_exp.size() > 0) begin
                e = q_exp.pop_front();
                r = q_req.pop_front();
                n_vec++;
                if (get_valid !== e.gv || (e.gv && get_data !== e.gd) || cond_done !== e.cd ||
                    cond_ok !== e.cok || resv_held !== e.held) begin
                    n_err++;
                    $display("FAIL %s: got gv=%0b gd=%h cd=%0b ok=%0b held=%0b exp gv=%0b gd=%h cd=%0b ok=%0b held=%0b",
                             r, get_valid, get_data, cond_done, cond_ok, resv_held,
                             e.gv, e.gd, e.cd, e.cok, e.held);
                end
            end
        end
    end

    task automatic wrap_up;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    endtask

    initial begin
        #(20 * 20000);
        n_err++;
        $display("FAIL watchdog: got hang expected completion");
        wrap_up();
    end

    initial begin
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        n_vec++;
        if (resv_held !== 1'b0 || get_valid !== 1'b0 || cond_done !== 1'b0) begin
            n_err++;
            $display("FAIL R1: got held=%0b gv=%0b cd=%0b expected 0 0 0", resv_held, get_valid, cond_done);
        end
        rst = 1'b0;
        idle("R1");
        step("R4", 1, 2'd1, 32'h0000_1000, 32'h11, 0, 0, 0);          // no reservation
        step("R8", 1, 2'd2, 32'h0000_1000, 32'hAA, 0, 0, 0);          // unconditional write
        step("R2", 1, 2'd0, 32'h0000_1040, 32'h0, 0, 0, 0);           // same granule
        step("R3", 1, 2'd1, 32'h0000_107F, 32'hBB, 0, 0, 0);          // commit, offset ignored
        idle("R10");
        step("R3", 1, 2'd0, 32'h0000_1000, 32'h0, 0, 0, 0);           // read back BB
        step("R5", 1, 2'd1, 32'h0000_2000, 32'hCC, 0, 0, 0);          // other line: fail, clear
        step("R4", 1, 2'd0, 32'h0000_2000, 32'h0, 0, 0, 0);           // line unchanged
        step("R6", 0, 2'd3, 32'h0, 32'h0, 1, 32'h0000_3000, 32'h33);  // other-line snoop
        step("R6", 0, 2'd3, 32'h0, 32'h0, 1, 32'h0000_2010, 32'hDD);  // kills reservation
        step("R6", 1, 2'd1, 32'h0000_2000, 32'hEE, 0, 0, 0);
        step("R6", 1, 2'd0, 32'h0000_2000, 32'h0, 0, 0, 0);           // sees DD
        step("R7", 1, 2'd0, 32'h0000_4000, 32'h0, 0, 0, 0);           // replace
        step("R7", 1, 2'd1, 32'h0000_2000, 32'h77, 0, 0, 0);          // old line fails
        step("R8", 1, 2'd0, 32'h0000_4000, 32'h0, 0, 0, 0);
        step("R8", 1, 2'd2, 32'h0000_5000, 32'h55, 0, 0, 0);          // keeps reservation
        step("R8", 1, 2'd2, 32'h0000_4020, 32'h44, 0, 0, 0);          // clears it
        step("R8", 1, 2'd1, 32'h0000_4000, 32'h99, 0, 0, 0);
        step("R9", 1, 2'd0, 32'h0000_6000, 32'h0, 0, 0, 0);
        step("R9", 1, 2'd1, 32'h0000_6000, 32'h61, 1, 32'h0000_6040, 32'h62);
        step("R9", 1, 2'd0, 32'h0000_6000, 32'h0, 0, 0, 0);           // snoop data won
        step("R9", 1, 2'd0, 32'h0000_7000, 32'h0, 1, 32'h0000_7000, 32'h70);
        step("R9", 1, 2'd1, 32'h0000_7000, 32'h71, 0, 0, 0);
        step("R10", 1, 2'd0, 32'h0000_1000, 32'h0, 0, 0, 0);
        step("R10", 1, 2'd3, 32'h0000_1000, 32'h12, 0, 0, 0);         // no-op
        step("R10", 1, 2'd0, 32'h0000_1000, 32'h0, 0, 0, 0);
        idle("R10");
        idle("R10");
        @(posedge clk);
        #10;
        wrap_up();
    end

endmodule